// File: doc/BRIEF.md
# Program Counter and Trap Sequencer

This block holds the fetch address state of a simple in-order core: the address of the instruction now executing and the address that follows it. Each time an instruction retires, the block commits a new current address. That address is the sequential successor, a branch target, or a fixed trap vector. The following address is always recomputed as the committed address plus the instruction size.

An illegal instruction traps. The block copies the current address and the machine state word into two save registers. It sets a cause bit in the state word, counted from the most-significant end, and redirects to the vector. The redirect overrides any branch or state update that the instruction carried. A halt instruction freezes the block until the next reset.

Retirement arrives as a valid/ready handshake. `retire_ready` is high whenever the block is not halted. While halted, `retire_ready` is low and any presented retirement is neither accepted nor acted on. A retirement is accepted in a cycle where `retire_valid` and `retire_ready` are both high. The branch, illegal, halt and state-write inputs are only sampled with an accepted retirement.

Top module: `pc_trap_sequencer`

## Requirements
- R1: During and after reset (async, active-low `rst_n`), `cur_addr` equals `rst_vector`, `next_addr` equals `rst_vector + 4`, the save registers and `state_word` are zero, `halted` is 0 and `retire_ready` is 1.
- R2: Out of reset, `next_addr` always equals `cur_addr + 4` (modulo 2^64).
- R3: An accepted retirement with `br_valid`, `illegal` and `halt_req` all low moves the old `next_addr` into `cur_addr` on the next edge.
- R4: An accepted retirement with `br_valid` high and `illegal`, `halt_req` low loads `br_target` into `cur_addr`.
- R5: An accepted retirement with `illegal` high loads the trap vector 0x700 into `cur_addr`, whatever `br_valid`/`br_target` say.
- R6: On a trap, `save_addr` receives the `cur_addr` of the trapping instruction and `save_state` receives the `state_word` held before the trap.
- R7: On a trap, `state_word` bit 63−N (N = 44 by default, so bit 19) is set and all other bits are kept; `state_we` is ignored.
- R8: An accepted retirement that is neither illegal nor a halt, with `state_we` high, loads `state_wdata` into `state_word`.
- R9: An accepted retirement with `halt_req` high and `illegal` low sets `halted`, leaves both addresses unchanged, and drops `retire_ready`.
- R10: While `halted` is 1, `retire_valid` has no effect: no address, save register or state word changes, and `halted` stays 1 until reset.
- R11: With `illegal` and `halt_req` both high on an accepted retirement, the trap is taken (R5–R7) and `halted` stays 0.
- R12: Without an accepted retirement, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_vector | input | 64 | Address loaded into `cur_addr` by reset |
| retire_valid | input | 1 | An instruction is retiring this cycle |
| retire_ready | output | 1 | Block accepts retirements (low when halted) |
| br_valid | input | 1 | Retiring instruction redirects to `br_target` |
| br_target | input | 64 | Branch target address |
| illegal | input | 1 | Retiring instruction is illegal; take the trap |
| halt_req | input | 1 | Retiring instruction is a halt |
| state_we | input | 1 | Retiring instruction writes the state word |
| state_wdata | input | 64 | New state word value |
| cur_addr | output | 64 | Current instruction address |
| next_addr | output | 64 | Sequential successor address |
| save_addr | output | 64 | Address saved by the last trap |
| save_state | output | 64 | State word saved by the last trap |
| state_word | output | 64 | Machine state word |
| halted | output | 1 | Execution stopped |

## Verification
Every internal register of this block is itself a port, so a wrong internal state shows at the outputs one edge after the retirement that caused it. The bench exploits this by comparing all outputs against a behavioural model after every clock. A bad priority between trap, halt and branch shows up immediately in `cur_addr` or `halted`. A misplaced cause bit or a save taken from the wrong cycle appears in `state_word` or `save_state` on the cycle after the trap. A leak through the halted state shows up as motion in any held output.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  // What one cycle does to the sequencer
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,  // no accepted retirement
    ACT_ADV  = 2'd1,  // sequential or branch commit
    ACT_TRAP = 2'd2,  // illegal-instruction redirect
    ACT_STOP = 2'd3   // halt
  } pc_act_e;
endpackage

// File: rtl/pc_act_decode.sv
module pc_act_decode
  import pcseq_pkg::*;
(
  input  logic    retire_valid,
  input  logic    halted,
  input  logic    illegal,
  input  logic    halt_req,
  output logic    retire_ready,
  output pc_act_e act
);
  logic accept;

  assign retire_ready = ~halted;
  assign accept       = retire_valid & retire_ready;

  // Trap outranks halt, halt outranks a plain commit
  always_comb begin
    if (!accept)       act = ACT_HOLD;
    else if (illegal)  act = ACT_TRAP;
    else if (halt_req) act = ACT_STOP;
    else               act = ACT_ADV;
  end
endmodule

// File: rtl/pc_addr_regs.sv
module pc_addr_regs
  import pcseq_pkg::*;
#(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned INSN_BYTES = 4,
  parameter logic [XLEN-1:0] TRAP_VEC = XLEN'(64'h700)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] rst_vector,
  input  pc_act_e         act,
  input  logic            br_valid,
  input  logic [XLEN-1:0] br_target,
  output logic [XLEN-1:0] cur_addr,
  output logic [XLEN-1:0] next_addr
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] commit_addr;
  logic            do_load;

  always_comb begin
    do_load     = 1'b1;
    commit_addr = next_addr;
    unique case (act)
      ACT_TRAP: commit_addr = TRAP_VEC;
      ACT_ADV:  commit_addr = br_valid ? br_target : next_addr;
      default:  do_load = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr  <= rst_vector;
      next_addr <= rst_vector + STEP;
    end else if (do_load) begin
      cur_addr  <= commit_addr;
      next_addr <= commit_addr + STEP;
    end
  end

  // R2
  next_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    next_addr == cur_addr + STEP);
  // R5
  trap_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_TRAP |=> cur_addr == TRAP_VEC);
  // R3
  seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_ADV && !br_valid) |=> cur_addr == $past(next_addr));
  // R12
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_HOLD || act == ACT_STOP) |=> $stable(cur_addr));
endmodule

// File: rtl/pc_trap_state.sv
module pc_trap_state
  import pcseq_pkg::*;
#(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned CAUSE_N = 44
) (
  input  logic            clk,
  input  logic            rst_n,
  input  pc_act_e         act,
  input  logic [XLEN-1:0] cur_addr,
  input  logic            state_we,
  input  logic [XLEN-1:0] state_wdata,
  output logic [XLEN-1:0] save_addr,
  output logic [XLEN-1:0] save_state,
  output logic [XLEN-1:0] state_word
);
  // Cause index counts from the most-significant end
  localparam int unsigned CAUSE_POS = XLEN - 1 - CAUSE_N;
  localparam logic [XLEN-1:0] CAUSE_MASK = XLEN'(1) << CAUSE_POS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      save_addr  <= '0;
      save_state <= '0;
      state_word <= '0;
    end else begin
      unique case (act)
        ACT_TRAP: begin
          save_addr  <= cur_addr;
          save_state <= state_word;
          state_word <= state_word | CAUSE_MASK;
        end
        ACT_ADV: if (state_we) state_word <= state_wdata;
        default: ;
      endcase
    end
  end

  // R6
  save_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_TRAP |=> (save_addr == $past(cur_addr) && save_state == $past(state_word)));
  // R7
  cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_TRAP |=> (state_word[CAUSE_POS] &&
      ((state_word & ~CAUSE_MASK) == ($past(state_word) & ~CAUSE_MASK))));
  // R12
  hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act != ACT_TRAP |=> ($stable(save_addr) && $stable(save_state)));
endmodule

// File: rtl/pc_halt_flag.sv
module pc_halt_flag
  import pcseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  pc_act_e act,
  output logic    halted
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                halted <= 1'b0;
    else if (act == ACT_STOP)  halted <= 1'b1;
  end

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  // R10
  halt_no_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> act == ACT_HOLD);
  // R11
  trap_not_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_TRAP && !halted) |=> !halted);
endmodule

// File: rtl/pc_trap_sequencer.sv
module pc_trap_sequencer
  import pcseq_pkg::*;
#(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned INSN_BYTES = 4,
  parameter int unsigned CAUSE_N    = 44,
  parameter logic [XLEN-1:0] TRAP_VEC = XLEN'(64'h700)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] rst_vector,
  input  logic            retire_valid,
  output logic            retire_ready,
  input  logic            br_valid,
  input  logic [XLEN-1:0] br_target,
  input  logic            illegal,
  input  logic            halt_req,
  input  logic            state_we,
  input  logic [XLEN-1:0] state_wdata,
  output logic [XLEN-1:0] cur_addr,
  output logic [XLEN-1:0] next_addr,
  output logic [XLEN-1:0] save_addr,
  output logic [XLEN-1:0] save_state,
  output logic [XLEN-1:0] state_word,
  output logic            halted
);
  pc_act_e act;

  pc_act_decode u_dec (
    .retire_valid (retire_valid),
    .halted       (halted),
    .illegal      (illegal),
    .halt_req     (halt_req),
    .retire_ready (retire_ready),
    .act          (act)
  );

  pc_addr_regs #(
    .XLEN(XLEN), .INSN_BYTES(INSN_BYTES), .TRAP_VEC(TRAP_VEC)
  ) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_vector (rst_vector),
    .act        (act),
    .br_valid   (br_valid),
    .br_target  (br_target),
    .cur_addr   (cur_addr),
    .next_addr  (next_addr)
  );

  pc_trap_state #(.XLEN(XLEN), .CAUSE_N(CAUSE_N)) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .act         (act),
    .cur_addr    (cur_addr),
    .state_we    (state_we),
    .state_wdata (state_wdata),
    .save_addr   (save_addr),
    .save_state  (save_state),
    .state_word  (state_word)
  );

  pc_halt_flag u_halt (
    .clk    (clk),
    .rst_n  (rst_n),
    .act    (act),
    .halted (halted)
  );

  // R4
  branch_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && retire_ready && br_valid && !illegal && !halt_req)
      |=> cur_addr == $past(br_target));
  // R9
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && retire_ready && halt_req && !illegal)
      |=> (halted && !retire_ready && $stable(cur_addr)));
endmodule

// File: tb/test_pc_trap_sequencer.sv
module test_pc_trap_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] rst_vector = 64'h0000_0000_0001_0000;
  logic        retire_valid = 1'b0, br_valid = 1'b0, illegal = 1'b0;
  logic        halt_req = 1'b0, state_we = 1'b0;
  logic [63:0] br_target = '0, state_wdata = '0;
  logic        retire_ready, halted;
  logic [63:0] cur_addr, next_addr, save_addr, save_state, state_word;

  int checks = 0, failures = 0;

  // reference state
  logic [63:0] m_cur, m_sa, m_ss, m_st;
  logic        m_halt;
  localparam logic [63:0] VEC   = 64'h700;
  localparam logic [63:0] CAUSE = 64'h1 << 19;

  always #4 clk = ~clk;  // 125 MHz

  pc_trap_sequencer i_pc_trap_sequencer (
    .clk(clk), .rst_n(rst_n), .rst_vector(rst_vector),
    .retire_valid(retire_valid), .retire_ready(retire_ready),
    .br_valid(br_valid), .br_target(br_target), .illegal(illegal),
    .halt_req(halt_req), .state_we(state_we), .state_wdata(state_wdata),
    .cur_addr(cur_addr), .next_addr(next_addr), .save_addr(save_addr),
    .save_state(save_state), .state_word(state_word), .halted(halted)
  );

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk(tag, "cur_addr",   cur_addr,   m_cur);
    chk(tag, "next_addr",  next_addr,  m_cur + 64'd4);
    chk(tag, "save_addr",  save_addr,  m_sa);
    chk(tag, "save_state", save_state, m_ss);
    chk(tag, "state_word", state_word, m_st);
    chk(tag, "halted",     64'(halted),       64'(m_halt));
    chk(tag, "retire_ready", 64'(retire_ready), 64'(!m_halt));
  endtask

  // Called at a negedge; drives one cycle, advances the model, compares at the next negedge
  task automatic step(logic r, logic b, logic [63:0] t, logic il, logic h,
                      logic we, logic [63:0] wd, string tag);
    retire_valid = r; br_valid = b; br_target = t; illegal = il;
    halt_req = h; state_we = we; state_wdata = wd;
    if (r && !m_halt) begin
      if (il) begin
        m_sa = m_cur; m_ss = m_st; m_st = m_st | CAUSE; m_cur = VEC;
      end else if (h) begin
        m_halt = 1'b1;
      end else begin
        m_cur = b ? t : m_cur + 64'd4;
        if (we) m_st = wd;
      end
    end
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    retire_valid = 0; br_valid = 0; illegal = 0; halt_req = 0; state_we = 0;
    m_cur = rst_vector; m_sa = '0; m_ss = '0; m_st = '0; m_halt = 1'b0;
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    step(1, 0, '0, 0, 0, 0, '0, "R3");
    step(1, 0, '0, 0, 0, 0, '0, "R3");
    step(0, 1, 64'hDEAD_0000, 1, 1, 1, 64'hFFFF, "R12");
    step(1, 1, 64'h0000_8000_0000_1230, 0, 0, 0, '0, "R4");
    step(1, 0, '0, 0, 0, 1, 64'hA5A5_0000_0000_0003, "R8");
    step(1, 1, 64'h4444, 1, 0, 1, 64'h1111, "R5");   // branch and write lost to trap
    step(1, 0, '0, 0, 0, 0, '0, "R6");
    step(1, 0, '0, 1, 0, 0, '0, "R7");               // second trap: bit already set
    step(1, 1, 64'hFFFF_FFFF_FFFF_FFFC, 0, 0, 0, '0, "R2"); // next wraps
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rv = $urandom;
      step(rv[0] | rv[1], rv[2], {$urandom, $urandom} & ~64'h3, rv[5:3] == 3'd0,
           1'b0, rv[6], {$urandom, $urandom}, "R2");
    end
    step(1, 0, '0, 1, 1, 0, '0, "R11");
    step(1, 0, '0, 0, 0, 0, '0, "R11");
    step(1, 1, 64'h2000, 0, 1, 1, 64'h77, "R9");
    step(1, 0, '0, 0, 0, 0, '0, "R10");
    step(1, 1, 64'h3000, 0, 0, 1, 64'h99, "R10");
    step(1, 0, '0, 1, 0, 0, '0, "R10");
    rst_vector = 64'h0000_0000_0000_0100;
    do_reset();
    step(1, 0, '0, 0, 0, 0, '0, "R3");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule